// File: doc/BRIEF.md
# Receive Frame Qualifier

This block sits behind the preamble stripper of an Ethernet receive path. It takes the frame one byte per transfer, with start-of-frame and end-of-frame markers on the same transfer as the first and last byte. The trailing four CRC bytes are part of the stream. When the sixth byte arrives, the block classifies the destination address. That sixth byte is the last byte of the address. It then decides whether the frame passes the address filter. It tells a downstream receive FIFO to keep the frame only once a 64-byte collision window has gone by. Runts and filtered frames are rejected.

The block counts the frame length and flags frames longer than a programmable maximum. Long frames are never truncated: a one-cycle babble pulse is raised instead. At the end of every accepted frame it emits a 32-bit status word with a one-cycle strobe. It also sets a pending frame-received flag, which reaches the interrupt pin only while the interrupt enable is high.

The input is a valid/ready stream. `in_ready` is always high, so the block never applies back-pressure. A byte transfers on every clock edge with `in_valid` high. The sender may leave idle cycles, with `in_valid` low, anywhere inside a frame. Marker inputs and the error inputs are only looked at on transfers.

Top module: `rx_frame_qualifier`

## Requirements
- R1: After reset all outputs except `in_ready` are low, and `in_ready` stays high. A transfer that is neither inside a frame nor marked as start of frame is ignored: it produces no pulse, no status, and does not disturb the length of the next frame.
- R2: The destination address is the first six bytes, and the first byte holds address bits [7:0]. It is broadcast when all 48 bits are one. It is multicast when bit 0 of the first byte is one and it is not broadcast. Otherwise it is unicast, and it passes only if it equals `station_addr`. Broadcast and multicast frames always pass.
- R3: A frame that fails the address filter with `promisc` low causes one `fifo_reject` pulse in the cycle after its sixth byte. It then gets no accept and no status.
- R4: With `promisc` high every address passes. An accepted frame whose address was neither broadcast, multicast nor a station match has the miss flag, status bit 23, set.
- R5: A frame not rejected by the filter causes one `fifo_accept` pulse in the cycle after its 64th byte.
- R6: A frame that ends before 64 bytes and was not already rejected by the filter gets one `fifo_reject` pulse in the cycle after its last byte. This includes frames shorter than six bytes. Such a frame produces no status.
- R7: The length in status bits [10:0] counts every byte, CRC included, and saturates at 2047. Status bit 16 is set when the frame ran past 2047 bytes.
- R8: On the first byte whose count exceeds `max_len`, `babble_err` pulses for one cycle. Status bit 20 is set, and the frame is still counted to its full length.
- R9: For an accepted frame, `stat_valid` pulses in the cycle after the last byte. Status bit 22 marks broadcast and bit 21 multicast. Bits 18, 19 and 17 copy `crc_err`, `align_err` and `ovr_err` from the end-of-frame transfer. Bits 31:24 and 15:11 are zero.
- R10: Every status strobe sets a pending flag. `irq` shows that flag ANDed with `irq_en`. A pulse on `irq_ack` clears the flag, and a new status strobe wins over a same-cycle clear.
- R11: A start-of-frame transfer always begins a new frame. A frame cut off this way before its end marker and before 64 bytes produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte transfer present |
| in_ready | output | 1 | Always high: no back-pressure |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| crc_err | input | 1 | CRC check failed, valid with end of frame |
| align_err | input | 1 | Frame not a whole number of bytes, valid with end of frame |
| ovr_err | input | 1 | Receive overrun, valid with end of frame |
| station_addr | input | 48 | Own unicast address, first byte in [7:0] |
| promisc | input | 1 | Pass every destination address |
| max_len | input | 11 | Longest frame length before babble |
| irq_en | input | 1 | Frame-received interrupt enable |
| irq_ack | input | 1 | Clear pending frame-received flag |
| fifo_accept | output | 1 | Keep the current frame (pulse) |
| fifo_reject | output | 1 | Drop the current frame (pulse) |
| babble_err | output | 1 | Frame exceeded max_len (pulse) |
| stat_valid | output | 1 | Status word strobe |
| stat_word | output | 32 | Frame status, held until next strobe |
| irq | output | 1 | Masked frame-received request |

## Verification
Every decision in this block leaves a pulse on a port one cycle after the byte that caused it. A wrong byte count, a stale address class or a stuck reject flag therefore shows up as an event missing, extra or one cycle off at the 6th, 64th, max_len+1th or last byte of the same frame. A flag that is not cleared on a new start marker shows up in the next frame's status word or as a missing accept. The scoreboard predicts the exact sequence of pulses and status words from the frame length, the address and the settings. It compares them in the order the design produces them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LEN_W    = 11;
  localparam int DA_BYTES = 6;
  localparam int WIN_BYTES = 64;
  localparam int STAT_W   = 32;

  typedef struct packed {
    logic miss;
    logic bcast;
    logic mcast;
    logic too_long;
    logic odd_bits;
    logic crc_bad;
    logic overrun;
    logic sat;
  } rxq_flags_t;

  function automatic logic [STAT_W-1:0] rxq_pack(input rxq_flags_t f,
                                                 input logic [LEN_W-1:0] len);
    logic [STAT_W-1:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[23:16] = f;
    return w;
  endfunction
endpackage

// File: rtl/rxq_len_ctr.sv
module rxq_len_ctr #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] cnt_n,
  output logic             lg_n,
  output logic             tr_n,
  output logic             babble_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt_q;
  logic lg_q, tr_q, lg_base, tr_base;

  always_comb begin
    lg_base = sof ? 1'b0 : lg_q;
    tr_base = sof ? 1'b0 : tr_q;
    if (sof)                cnt_n = LEN_W'(1);
    else if (cnt_q == CNT_MAX) cnt_n = CNT_MAX;
    else                    cnt_n = cnt_q + LEN_W'(1);
    tr_n = tr_base | (!sof && cnt_q == CNT_MAX);
    lg_n = lg_base | (cnt_n > max_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lg_q     <= 1'b0;
      tr_q     <= 1'b0;
      babble_o <= 1'b0;
    end else begin
      babble_o <= beat && lg_n && !lg_base;
      if (beat) begin
        cnt_q <= cnt_n;
        lg_q  <= lg_n;
        tr_q  <= tr_n;
      end
    end
  end

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + LEN_W'(1)));
  a_r8_babble_once: assert property (@(posedge clk) disable iff (!rst_n)
    babble_o |=> !babble_o);
  a_r8_babble_sets_lg: assert property (@(posedge clk) disable iff (!rst_n)
    babble_o |-> lg_q);
endmodule

// File: rtl/rxq_addr_filter.sv
module rxq_addr_filter #(
  parameter int LEN_W    = 11,
  parameter int DA_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat,
  input  logic [LEN_W-1:0]      pos,
  input  logic [7:0]            data,
  input  logic [8*DA_BYTES-1:0] station_addr,
  output logic                  is_bc,
  output logic                  is_mc,
  output logic                  uc_hit
);
  localparam int HELD = DA_BYTES - 1;

  logic [7:0] held_q [HELD];
  logic [8*DA_BYTES-1:0] da_full;

  for (genvar i = 0; i < HELD; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               held_q[i] <= '0;
      else if (beat && pos == LEN_W'(i + 1))     held_q[i] <= data;
    end
    assign da_full[8*i +: 8] = held_q[i];
  end
  assign da_full[8*HELD +: 8] = data;

  always_comb begin
    is_bc  = &da_full;
    is_mc  = da_full[0] && !is_bc;
    uc_hit = (da_full == station_addr);
  end
endmodule

// File: rtl/rxq_irq_ctl.sv
module rxq_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic ack,
  input  logic enable,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (done) flag_q <= 1'b1;
    else if (ack)  flag_q <= 1'b0;
  end

  assign irq = flag_q && enable;

  a_r10_flag_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done) |=> !flag_q);
endmodule

// File: rtl/rx_frame_qualifier.sv
module rx_frame_qualifier
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              crc_err,
  input  logic              align_err,
  input  logic              ovr_err,
  input  logic [47:0]       station_addr,
  input  logic              promisc,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              fifo_accept,
  output logic              fifo_reject,
  output logic              babble_err,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq
);
  logic in_frame_q, rej_q, bc_q, mc_q, miss_q;
  logic beat, sof;
  logic [LEN_W-1:0] cnt_n;
  logic lg_n, tr_n;
  logic is_bc, is_mc, uc_hit;
  logic addr_now, pass, rej_base, rej_addr, runt_rej, win_hit, done_now;
  rxq_flags_t flags;

  assign in_ready = 1'b1;
  assign beat = in_valid && (in_sof || in_frame_q);
  assign sof  = in_sof;

  rxq_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(sof), .max_len(max_len),
    .cnt_n(cnt_n), .lg_n(lg_n), .tr_n(tr_n), .babble_o(babble_err)
  );

  rxq_addr_filter #(.LEN_W(LEN_W), .DA_BYTES(DA_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .pos(cnt_n), .data(in_data),
    .station_addr(station_addr), .is_bc(is_bc), .is_mc(is_mc), .uc_hit(uc_hit)
  );

  always_comb begin
    addr_now = beat && cnt_n == LEN_W'(DA_BYTES);
    pass     = promisc || is_bc || is_mc || uc_hit;
    rej_base = sof ? 1'b0 : rej_q;
    rej_addr = addr_now && !pass;
    win_hit  = beat && cnt_n == LEN_W'(WIN_BYTES) && !rej_base;
    runt_rej = beat && in_eof && cnt_n < LEN_W'(WIN_BYTES) && !rej_base && !rej_addr;
    done_now = beat && in_eof && cnt_n >= LEN_W'(WIN_BYTES) && !rej_base;
    flags.miss     = miss_q;
    flags.bcast    = bc_q;
    flags.mcast    = mc_q;
    flags.too_long = lg_n;
    flags.odd_bits = align_err;
    flags.crc_bad  = crc_err;
    flags.overrun  = ovr_err;
    flags.sat      = tr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      rej_q       <= 1'b0;
      bc_q        <= 1'b0;
      mc_q        <= 1'b0;
      miss_q      <= 1'b0;
      fifo_accept <= 1'b0;
      fifo_reject <= 1'b0;
      stat_valid  <= 1'b0;
      stat_word   <= '0;
    end else begin
      fifo_accept <= win_hit;
      fifo_reject <= rej_addr || runt_rej;
      stat_valid  <= done_now;
      if (beat) begin
        in_frame_q <= !in_eof;
        rej_q      <= rej_base || rej_addr;
        if (sof) begin
          bc_q   <= 1'b0;
          mc_q   <= 1'b0;
          miss_q <= 1'b0;
        end
        if (addr_now) begin
          bc_q   <= is_bc;
          mc_q   <= is_mc;
          miss_q <= !(is_bc || is_mc || uc_hit);
        end
      end
      if (done_now) stat_word <= rxq_pack(flags, cnt_n);
    end
  end

  rxq_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .done(stat_valid), .ack(irq_ack),
    .enable(irq_en), .irq(irq)
  );

  a_r3_accept_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_accept && fifo_reject));
  a_r5_accept_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_accept |=> !fifo_accept);
  a_r9_stat_len_min: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_word[LEN_W-1:0] >= LEN_W'(WIN_BYTES)));
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/tb_rx_frame_qualifier.sv
module tb_rx_frame_qualifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic crc_err = 1'b0, align_err = 1'b0, ovr_err = 1'b0;
  logic [47:0] station_addr = 48'h5544_3322_1102;
  logic promisc = 1'b0;
  logic [10:0] max_len = 11'd1518;
  logic irq_en = 1'b1, irq_ack = 1'b0;
  logic in_ready, fifo_accept, fifo_reject, babble_err, stat_valid, irq;
  logic [31:0] stat_word;

  int checks = 0;
  int failures = 0;
  int exp_kind[$];
  logic [31:0] exp_data[$];
  bit done_flag = 1'b0;

  localparam int K_REJ = 0, K_ACC = 1, K_BAB = 2, K_STAT = 3;

  always #4 clk = ~clk;

  rx_frame_qualifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .crc_err(crc_err),
    .align_err(align_err), .ovr_err(ovr_err), .station_addr(station_addr),
    .promisc(promisc), .max_len(max_len), .irq_en(irq_en), .irq_ack(irq_ack),
    .fifo_accept(fifo_accept), .fifo_reject(fifo_reject), .babble_err(babble_err),
    .stat_valid(stat_valid), .stat_word(stat_word), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input int kind, input logic [31:0] act);
    int k;
    logic [31:0] d;
    if (exp_kind.size() == 0) begin
      check(1'b0, "R1/R11 unexpected event", 32'(kind), 32'hFFFF_FFFF);
    end else begin
      k = exp_kind.pop_front();
      d = exp_data.pop_front();
      if (kind == K_STAT)
        check(k == kind && act == d, "R9/R7 status word", act, d);
      else
        check(k == kind, "R3/R5/R6/R8 event kind", 32'(kind), 32'(k));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_reject) pop_cmp(K_REJ, 32'h0);
      if (fifo_accept) pop_cmp(K_ACC, 32'h0);
      if (babble_err)  pop_cmp(K_BAB, 32'h0);
      if (stat_valid)  pop_cmp(K_STAT, stat_word);
    end
  end

  task automatic push(input int k, input logic [31:0] d);
    exp_kind.push_back(k);
    exp_data.push_back(d);
  endtask

  task automatic predict(input int len, input logic [47:0] da, input bit c,
                         input bit a, input bit o);
    bit bc, mc, hit, pass, rej;
    int n;
    bc = &da;
    mc = da[0] && !bc;
    hit = (da == station_addr);
    pass = promisc || bc || mc || hit;
    rej = 1'b0;
    for (int b = 1; b <= len; b++) begin
      if (b == 6 && !pass) begin push(K_REJ, 0); rej = 1'b1; end
      if (b == len && len < 64 && !rej) push(K_REJ, 0);
      if (b == 64 && !rej) push(K_ACC, 0);
      if (int'(max_len) < 2047 && b == int'(max_len) + 1) push(K_BAB, 0);
      if (b == len && len >= 64 && !rej) begin
        n = (len > 2047) ? 2047 : len;
        push(K_STAT, {8'h0, !(bc || mc || hit), bc, mc, len > int'(max_len),
                      a, c, o, len > 2047, 5'h0, 11'(n)});
      end
    end
  endtask

  task automatic drive(input int len, input logic [47:0] da, input bit c,
                       input bit a, input bit o, input bit with_eof);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      if (b % 7 == 6) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = (b < 6) ? da[8*b +: 8] : 8'(b);
      in_sof   = (b == 0);
      in_eof   = with_eof && (b == len - 1);
      crc_err  = in_eof && c;
      align_err = in_eof && a;
      ovr_err  = in_eof && o;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    crc_err = 1'b0; align_err = 1'b0; ovr_err = 1'b0;
  endtask

  task automatic frame(input int len, input logic [47:0] da, input bit c,
                       input bit a, input bit o);
    predict(len, da, c, a, o);
    drive(len, da, c, a, o, 1'b1);
    repeat (3) @(negedge clk);
    check(exp_kind.size() == 0, "R5/R6 all expected events seen",
          32'(exp_kind.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!fifo_accept && !fifo_reject && !babble_err && !stat_valid && !irq,
          "R1 reset outputs low", {27'h0, fifo_accept, fifo_reject, babble_err, stat_valid, irq}, 0);
    check(stat_word == 0, "R1 reset status", stat_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R1 ready high", 32'(in_ready), 1);

    // R2 R5 R9: unicast match, exactly 64 bytes
    frame(64, station_addr, 0, 0, 0);
    // R10: flag pending and enabled
    check(irq, "R10 irq after status", 32'(irq), 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; @(negedge clk);
    check(!irq, "R10 irq cleared by ack", 32'(irq), 0);

    // R2 R9: broadcast with crc error
    frame(70, 48'hFFFF_FFFF_FFFF, 1, 0, 0);
    // R2 R9: multicast with alignment and overrun
    frame(100, 48'h0000_0000_0033, 0, 1, 1);
    // R3: unicast mismatch
    frame(80, 48'h0000_0000_0A02, 0, 0, 0);
    // R4: promiscuous mismatch
    promisc = 1'b1;
    frame(64, 48'h0000_0000_0A02, 0, 0, 0);
    promisc = 1'b0;
    // R6: runts, one shorter than the address
    frame(30, station_addr, 0, 0, 0);
    frame(3, station_addr, 0, 0, 0);
    // R8: babble, not truncated
    max_len = 11'd100;
    frame(120, station_addr, 0, 0, 0);
    // R7: saturation beyond 2047 bytes
    max_len = 11'd1518;
    frame(2100, 48'hFFFF_FFFF_FFFF, 0, 0, 0);

    // R10: masked interrupt
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    irq_en = 1'b0;
    frame(65, station_addr, 0, 0, 0);
    check(!irq, "R10 irq masked", 32'(irq), 0);
    irq_en = 1'b1; @(negedge clk);
    check(irq, "R10 pending shows when enabled", 32'(irq), 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

    // R1: stray bytes outside any frame
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(i); in_eof = (i == 7);
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_kind.size() == 0 && !irq, "R1 stray bytes ignored", 32'(irq), 0);
    frame(66, station_addr, 0, 0, 0);

    // R11: aborted partial frame then a fresh one
    drive(10, station_addr, 0, 0, 0, 1'b0);
    frame(64, station_addr, 0, 0, 0);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule